// File: doc/BRIEF.md
# Reloadable One-Shot Waveform Timer

A down-counting timer driven by a count-source enable (`tick_i`), which may be a plain divided clock enable or another timer's underflow strobe. The count value is 16 bits wide: a low byte that acts as the prescaler and a high byte that acts as the counter proper. The two bytes are chained, so the block counts as one 16-bit value and reloads from a primary or a secondary reload pair. Four modes are provided: free-running, waveform (primary and secondary periods alternate and the pin toggles at every switch), single-period one-shot, and wait one-shot (a primary wait period followed by an active secondary period).

Start, stop, one-shot start and one-shot halt requests pass through a two-stage pipeline clocked by the count source, so software sees them through status flags that settle two count-source ticks later. A forced stop bypasses that pipeline. Register map (byte wide, `addr_i`): 0 control (write bit0 run, bit2 forced stop; read bit0 run, bit1 counting flag), 1 one-shot (write bit0 start, bit1 halt; read bit0 one-shot busy), 2 mode (bits 1:0, 0 free, 1 waveform, 2 one-shot, 3 wait one-shot), 3 low reload byte (write staged, read counter low byte), 4 high reload byte (write commits, read counter high byte), 5 secondary high byte (write staged, read back).

Top module: `tmr_wave_oneshot`

## Requirements
- R1: After reset the control readback is 0, irq_o and wave_o are 0, and ticks do not change the counter until the run bit has been set.
- R2: A write to address 3 changes nothing visible in the counter; a write to address 4 commits {high byte, staged low byte} and, when the timer is not counting, loads it into the counter at once.
- R3: After run is written to 1, the counting flag (control bit1) reads 0 after one tick and 1 after the second tick; the tick on which it rises does not decrement, the next one does.
- R4: After run is written to 0, the counting flag reads 1 after one tick and 0 after the second; both of those ticks still decrement, and later ticks leave the counter unchanged.
- R5: Writing control bit2 as 1 clears the run bit and the counting flag in the next clock cycle with no tick needed, and leaves the counter value unchanged.
- R6: In one-shot mode (2) the counter holds while no one-shot is busy; after a one-shot start the busy flag rises on the second tick, the counter then runs one period, and at its underflow reloads and clears busy.
- R7: A one-shot halt reloads the counter from the primary reload pair on the second tick and clears busy; clearing the run bit instead halts without any reload.
- R8: A one-shot start written while the counting flag is 0 is dropped: busy stays 0 and the counter keeps its value, even after counting resumes.
- R9: Each enabled tick decrements the 16-bit count; a tick at zero reloads it (primary in free mode); in waveform mode (1) the reload alternates primary and secondary and wave_o toggles at every underflow, starting at 0.
- R10: In waveform and wait one-shot modes, a high-byte write made while counting leaves the counter untouched and takes effect only at the next secondary-period underflow; of several such writes the last one is used.
- R11: In wait one-shot mode (3) wave_o stays 0 during the primary wait period, is 1 during the following secondary period, and returns to 0 with busy cleared at its underflow.
- R12: irq_o is a one-clock pulse in the cycle after each tick that underflows the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-source enable, one tick per cycle high |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| irq_o | output | 1 | Underflow pulse |
| wave_o | output | 1 | Waveform output pin |

## Verification
The hardest state to reach is a deferred period change: the timer must be counting in waveform mode, in its primary period, when two high-byte writes land, and the bench must then run the full primary and secondary periods to see the last written value appear only after the secondary underflow. The stimulus gets there by loading a long primary and a short secondary while stopped, starting, crossing one complete cycle, and then writing twice mid-primary before reading the counter. Random gaps between ticks keep the checks tied to tick count rather than clock count.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_WAVE = 2'd1,
    MODE_ONCE = 2'd2,
    MODE_WAIT = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    OS_NONE = 2'd0,
    OS_GO   = 2'd1,
    OS_HALT = 2'd2
  } os_req_e;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_OS   = 3'd1;
  localparam logic [2:0] A_MODE = 3'd2;
  localparam logic [2:0] A_LO   = 3'd3;
  localparam logic [2:0] A_HI   = 3'd4;
  localparam logic [2:0] A_SEC  = 3'd5;
endpackage

// File: rtl/tmr_tick_sync.sv
module tmr_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (clr_i)  sh_q <= '0;
    else if (tick_i) sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/tmr_oneshot_ctl.sv
module tmr_oneshot_ctl
  import tmr_wave_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic go_i,
  input  logic halt_i,
  input  logic done_i,
  output logic busy_o,
  output logic halt_apply_o
);
  os_req_e req_q, stage_q;
  logic    busy_q;

  assign halt_apply_o = tick_i && (stage_q == OS_HALT) && !clr_i;
  assign busy_o       = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= OS_NONE;
      stage_q <= OS_NONE;
      busy_q  <= 1'b0;
    end else if (clr_i) begin
      req_q   <= OS_NONE;
      stage_q <= OS_NONE;
      busy_q  <= 1'b0;
    end else begin
      if (done_i) busy_q <= 1'b0;
      if (tick_i) begin
        stage_q <= req_q;
        req_q   <= OS_NONE;
        if (stage_q == OS_GO)   busy_q <= 1'b1;
        if (stage_q == OS_HALT) busy_q <= 1'b0;
      end
      // a fresh write overrides a request still waiting for its first tick
      if (halt_i)    req_q <= OS_HALT;
      else if (go_i) req_q <= OS_GO;
    end
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_wave_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned CW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  tmr_mode_e     mode_i,
  input  logic          idle_i,
  input  logic          commit_i,
  input  logic [CW-1:0] commit_val_i,
  input  logic [DW-1:0] sec_i,
  input  logic          halt_apply_i,
  input  logic          force_i,
  output logic [CW-1:0] cnt_o,
  output logic          irq_o,
  output logic          wave_o,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] pri_q, lo_q, sec_q;
  logic [DW-1:0] pend_pri_q, pend_lo_q, pend_sec_q;
  logic          pend_q, sec_phase_q, wave_q, irq_q;
  logic          uf, defer, two_phase;
  logic [CW-1:0] pri_val, sec_val, next_pri;

  assign uf        = (cnt_q == '0);
  assign two_phase = (mode_i == MODE_WAVE) || (mode_i == MODE_WAIT);
  assign defer     = two_phase && !idle_i;
  assign pri_val   = {pri_q, lo_q};
  assign sec_val   = {sec_q, lo_q};
  assign next_pri  = pend_q ? {pend_pri_q, pend_lo_q} : pri_val;
  assign done_o    = step_i && uf && !halt_apply_i &&
                     ((mode_i == MODE_ONCE) || ((mode_i == MODE_WAIT) && sec_phase_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      pri_q       <= '0;
      lo_q        <= '0;
      sec_q       <= '0;
      pend_pri_q  <= '0;
      pend_lo_q   <= '0;
      pend_sec_q  <= '0;
      pend_q      <= 1'b0;
      sec_phase_q <= 1'b0;
      wave_q      <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      irq_q <= step_i && uf && !halt_apply_i;
      if (halt_apply_i) begin
        cnt_q       <= pri_val;
        sec_phase_q <= 1'b0;
        wave_q      <= 1'b0;
      end else if (step_i) begin
        if (!uf) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (!two_phase) begin
          cnt_q <= pri_val;
        end else if (!sec_phase_q) begin
          cnt_q       <= sec_val;
          sec_phase_q <= 1'b1;
          wave_q      <= (mode_i == MODE_WAVE) ? ~wave_q : 1'b1;
        end else begin
          cnt_q       <= next_pri;
          sec_phase_q <= 1'b0;
          wave_q      <= (mode_i == MODE_WAVE) ? ~wave_q : 1'b0;
          if (pend_q) begin
            pri_q  <= pend_pri_q;
            lo_q   <= pend_lo_q;
            sec_q  <= pend_sec_q;
            pend_q <= 1'b0;
          end
        end
      end
      if (force_i) begin
        sec_phase_q <= 1'b0;
        wave_q      <= 1'b0;
      end
      if (commit_i) begin
        if (defer) begin
          pend_q     <= 1'b1;
          pend_pri_q <= commit_val_i[CW-1:DW];
          pend_lo_q  <= commit_val_i[DW-1:0];
          pend_sec_q <= sec_i;
        end else begin
          pend_q <= 1'b0;
          pri_q  <= commit_val_i[CW-1:DW];
          lo_q   <= commit_val_i[DW-1:0];
          sec_q  <= sec_i;
          if (idle_i) begin
            cnt_q       <= commit_val_i;
            sec_phase_q <= 1'b0;
          end
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign irq_o  = irq_q;
  assign wave_o = wave_q;
endmodule

// File: rtl/tmr_wave_oneshot.sv
module tmr_wave_oneshot
  import tmr_wave_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          wave_o
);
  logic          run_q;
  tmr_mode_e     mode_q;
  logic [DW-1:0] lo_stage_q, sec_stage_q;
  logic          act, os_busy, halt_apply, os_done;
  logic          wr_ctrl, force_wr, go_wr, halt_wr, commit;
  logic          once_mode, count_en, idle, os_clr;
  logic [CW-1:0] cnt;

  assign wr_ctrl  = we_i && (addr_i == A_CTRL);
  assign force_wr = wr_ctrl && wdata_i[2];
  assign go_wr    = we_i && (addr_i == A_OS) && wdata_i[0] && act;
  assign halt_wr  = we_i && (addr_i == A_OS) && wdata_i[1] && act;
  assign commit   = we_i && (addr_i == A_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      mode_q      <= MODE_FREE;
      lo_stage_q  <= '0;
      sec_stage_q <= '0;
    end else begin
      if (force_wr)     run_q <= 1'b0;
      else if (wr_ctrl) run_q <= wdata_i[0];
      if (we_i && addr_i == A_MODE) mode_q      <= tmr_mode_e'(wdata_i[1:0]);
      if (we_i && addr_i == A_LO)   lo_stage_q  <= wdata_i;
      if (we_i && addr_i == A_SEC)  sec_stage_q <= wdata_i;
    end
  end

  tmr_tick_sync #(.STAGES(SYNC_STAGES)) i_run_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (force_wr),
    .d_i    (run_q),
    .q_o    (act)
  );

  assign once_mode = mode_q[1];
  assign count_en  = act && (!once_mode || os_busy);
  assign idle      = !act || (once_mode && !os_busy);
  assign os_clr    = force_wr || !act;

  tmr_oneshot_ctl i_os (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .clr_i        (os_clr),
    .go_i         (go_wr),
    .halt_i       (halt_wr),
    .done_i       (os_done),
    .busy_o       (os_busy),
    .halt_apply_o (halt_apply)
  );

  tmr_count_core #(.DW(DW)) i_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_i       (tick_i && count_en),
    .mode_i       (mode_q),
    .idle_i       (idle),
    .commit_i     (commit),
    .commit_val_i ({wdata_i, lo_stage_q}),
    .sec_i        (sec_stage_q),
    .halt_apply_i (halt_apply),
    .force_i      (force_wr),
    .cnt_o        (cnt),
    .irq_o        (irq_o),
    .wave_o       (wave_o),
    .done_o       (os_done)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o = {{(DW-2){1'b0}}, act, run_q};
      A_OS:    rdata_o = {{(DW-1){1'b0}}, os_busy};
      A_MODE:  rdata_o = {{(DW-2){1'b0}}, mode_q};
      A_LO:    rdata_o = cnt[DW-1:0];
      A_HI:    rdata_o = cnt[CW-1:DW];
      A_SEC:   rdata_o = sec_stage_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_wave_oneshot_chk.sv
module tmr_wave_oneshot_chk #(
  parameter int unsigned DW = 8,
  localparam int unsigned CW = 2 * DW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          we_i,
  input logic [2:0]    addr_i,
  input logic          force_bit_i,
  input logic          irq_i,
  input logic          act_i,
  input logic          busy_i,
  input logic [CW-1:0] cnt_i
);
  logic force_wr, hi_wr;
  assign force_wr = we_i && (addr_i == 3'd0) && force_bit_i;
  assign hi_wr    = we_i && (addr_i == 3'd4);

  p_flag_moves_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !force_wr) |=> $stable(act_i));

  p_frozen_when_stopped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_i && !hi_wr) |=> $stable(cnt_i));

  p_force_immediate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_wr |=> !act_i);

  p_busy_needs_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(act_i));

  p_irq_from_tick_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> $past(tick_i));
endmodule

bind tmr_wave_oneshot tmr_wave_oneshot_chk #(.DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .force_bit_i (wdata_i[2]),
  .irq_i       (irq_o),
  .act_i       (act),
  .busy_i      (os_busy),
  .cnt_i       (cnt)
);

// File: tb/test_tmr_wave_oneshot.sv
module test_tmr_wave_oneshot;
  localparam logic [2:0] A_CTRL = 3'd0, A_OS = 3'd1, A_MODE = 3'd2,
                         A_LO = 3'd3, A_HI = 3'd4, A_SEC = 3'd5;

  logic       clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, wave;
  int n_cmp = 0, n_bad = 0, irq_seen = 0, v = 0, cur = 0, n = 0, base = 0;
  logic last_irq = 1'b0, finished = 1'b0;

  always #2 clk = ~clk;

  tmr_wave_oneshot i_tmr_wave_oneshot (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wave_o(wave)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int r);
    @(negedge clk); addr = a; #1 r = int'(rdata);
  endtask

  task automatic tk(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      last_irq = irq;
      if (irq) irq_seen++;
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
  endtask

  function automatic int after_val(input int c, input int rel, input int k);
    if (k < c + 1) return c - k;
    return rel - ((k - (c + 1)) % (rel + 1));
  endfunction

  function automatic int uf_cnt(input int c, input int rel, input int k);
    if (k < c + 1) return 0;
    return 1 + (k - (c + 1)) / (rel + 1);
  endfunction

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 wave", int'(wave), 0);
    tk(3); rd(A_LO, v); chk("R1 no count before start", v, 0);

    // R2 staged low byte, commit on high byte
    wr(A_LO, 8'd5); rd(A_LO, v); chk("R2 low write staged", v, 0);
    wr(A_HI, 8'd0); rd(A_LO, v); chk("R2 commit low", v, 5);
    rd(A_HI, v); chk("R2 commit high", v, 0);

    // R3 start latency
    wr(A_CTRL, 8'h01);
    tk(1); rd(A_CTRL, v); chk("R3 flag after 1 tick", v, 1);
    tk(1); rd(A_CTRL, v); chk("R3 flag after 2 ticks", v, 3);
    rd(A_LO, v); chk("R3 rising tick does not count", v, 5);
    tk(2); rd(A_LO, v); chk("R9 decrement", v, 3);
    irq_seen = 0;
    tk(4); rd(A_LO, v); chk("R9 reload after underflow", v, 5);
    chk("R9 one irq", irq_seen, 1);
    chk("R12 irq on underflow tick", int'(last_irq), 1);
    @(negedge clk); chk("R12 irq one clock", int'(irq), 0);

    // R9 random run in free mode
    n = $urandom_range(10, 40); irq_seen = 0;
    tk(n); rd(A_LO, v); chk("R9 random count", v, after_val(5, 5, n));
    chk("R9 random irq count", irq_seen, uf_cnt(5, 5, n));
    cur = after_val(5, 5, n);

    // R4 stop latency, two counted ticks then frozen
    wr(A_CTRL, 8'h00);
    tk(1); rd(A_CTRL, v); chk("R4 flag still 1", v, 2);
    tk(1); rd(A_CTRL, v); chk("R4 flag 0", v, 0);
    cur = after_val(cur, 5, 2);
    rd(A_LO, v); chk("R4 counted during stop window", v, cur);
    tk(5); rd(A_LO, v); chk("R4 frozen", v, cur);

    // R5 forced stop
    wr(A_CTRL, 8'h01); tk(2);
    rd(A_CTRL, v); chk("R5 pre running", v, 3);
    wr(A_CTRL, 8'h05);
    rd(A_CTRL, v); chk("R5 immediate stop", v, 0);
    rd(A_LO, v); chk("R5 counter unchanged", v, cur);

    // R6 one-shot
    wr(A_MODE, 8'd2); wr(A_LO, 8'd2); wr(A_HI, 8'd0);
    wr(A_CTRL, 8'h01); tk(2);
    tk(3); rd(A_LO, v); chk("R6 holds while not busy", v, 2);
    wr(A_OS, 8'h01);
    tk(1); rd(A_OS, v); chk("R6 busy after 1 tick", v, 0);
    tk(1); rd(A_OS, v); chk("R6 busy after 2 ticks", v, 1);
    rd(A_LO, v); chk("R6 no count on busy edge", v, 2);
    irq_seen = 0;
    tk(2); rd(A_LO, v); chk("R6 counting", v, 0);
    tk(1); rd(A_OS, v); chk("R6 busy cleared", v, 0);
    rd(A_LO, v); chk("R6 reloaded", v, 2);
    chk("R6 irq", irq_seen, 1);
    tk(4); rd(A_LO, v); chk("R6 stays after end", v, 2);

    // R7 halt reloads, plain stop does not
    wr(A_LO, 8'd9); wr(A_HI, 8'd0);
    wr(A_OS, 8'h01); tk(2); tk(3);
    rd(A_LO, v); chk("R7 mid count", v, 6);
    wr(A_OS, 8'h02);
    tk(1); rd(A_LO, v); chk("R7 counting in halt window", v, 5);
    tk(1); rd(A_LO, v); chk("R7 halt reload", v, 9);
    rd(A_OS, v); chk("R7 halt clears busy", v, 0);
    wr(A_OS, 8'h01); tk(2); tk(3);
    wr(A_CTRL, 8'h00); tk(2);
    rd(A_LO, v); chk("R7 stop no reload", v, 4);
    rd(A_OS, v); chk("R7 busy after stop", v, 0);

    // R8 start ignored while flag is 0
    wr(A_OS, 8'h01); tk(4);
    rd(A_OS, v); chk("R8 busy stays 0", v, 0);
    wr(A_CTRL, 8'h01); tk(4);
    rd(A_OS, v); chk("R8 dropped request", v, 0);
    rd(A_LO, v); chk("R8 counter kept", v, 4);

    // R9 / R10 waveform with deferred update
    wr(A_CTRL, 8'h04); wr(A_MODE, 8'd1);
    wr(A_SEC, 8'd0); wr(A_LO, 8'd1); wr(A_HI, 8'd1);
    chk("R9 wave starts low", int'(wave), 0);
    wr(A_CTRL, 8'h01); tk(2);
    irq_seen = 0;
    tk(258); chk("R9 wave after primary", int'(wave), 1);
    rd(A_HI, v); chk("R9 secondary loaded", v, 0);
    tk(2); chk("R9 wave after secondary", int'(wave), 0);
    rd(A_HI, v); chk("R9 primary reloaded", v, 1);
    chk("R9 two irqs", irq_seen, 2);
    wr(A_HI, 8'd3); wr(A_HI, 8'd0);
    rd(A_HI, v); chk("R10 no immediate load", v, 1);
    tk(258); rd(A_HI, v); chk("R10 old primary kept", v, 0);
    chk("R10 wave in secondary", int'(wave), 1);
    tk(2); rd(A_HI, v); chk("R10 last write applied", v, 0);
    rd(A_LO, v); chk("R10 new primary low", v, 1);
    n = $urandom_range(10, 50); irq_seen = 0;
    tk(n);
    chk("R9 random wave level", int'(wave), (n / 2) % 2);
    chk("R9 random wave irqs", irq_seen, n / 2);
    rd(A_LO, v); chk("R9 random wave count", v, after_val(1, 1, n));

    // R11 wait one-shot
    wr(A_CTRL, 8'h04); wr(A_MODE, 8'd3);
    wr(A_SEC, 8'd0); wr(A_LO, 8'd2); wr(A_HI, 8'd0);
    wr(A_CTRL, 8'h01); tk(2);
    wr(A_OS, 8'h01); tk(2);
    rd(A_OS, v); chk("R11 busy", v, 1);
    chk("R11 low during wait", int'(wave), 0);
    base = irq_seen;
    tk(2); chk("R11 still low", int'(wave), 0);
    tk(1); chk("R11 high in secondary", int'(wave), 1);
    tk(2); chk("R11 still high", int'(wave), 1);
    tk(1); chk("R11 low at end", int'(wave), 0);
    rd(A_OS, v); chk("R11 busy cleared", v, 0);
    rd(A_LO, v); chk("R11 reloaded", v, 2);
    chk("R11 irqs", irq_seen - base, 2);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule